// File: doc/BRIEF.md
# Raster Timing Generator with Master and Slave Synchronisation

This block keeps the pixel and line position of a video raster, advancing once per pixel clock. A pixel counter wraps at a programmable line length and a line counter wraps at a programmable field length. A parity flag and a field-sequence counter follow the fields. A line-based active-video flag marks the lines between two programmable limits. Because the flag is derived from the line count, an active region always opens at the first pixel of a line.

In master mode the time base runs free and the block drives two raster reference outputs. The vertical one carries one selectable waveform: a 3-line or 2.5-line vertical sync, a field parity level, or a pulse that marks the first field of every 4, 8 or 12. The horizontal one carries a pulse with programmable start and stop pixels, which can be masked outside the active lines to give composite blanking.

In slave mode the same pins act as inputs. A qualified edge on the vertical reference re-phases the line counter after a programmable delay. It can also re-phase the pixel counter and the field phase. Otherwise the horizontal reference re-phases the pixel counter on its own edge. Between edges the time base keeps running free, so missing pulses do not disturb it.

Top module: `vtg_timing_gen`

## Requirements
- R1: After reset `pix_cnt`, `line_cnt` and `field_seq` are 0 and `field_odd` is 1. `pix_cnt` counts 0 to `cfg_line_len`-1 and then returns to 0. On that wrap `line_cnt` increments.
- R2: `line_cnt` returns to 0 after `cfg_field_len`-1. On that wrap `field_odd` toggles and `field_seq` advances.
- R3: `vid_active` is 1 exactly when `cfg_act_first` <= `line_cnt` <= `cfg_act_last`.
- R4: In slave mode (`cfg_master`=0) a vertical edge is detected at a clock edge where `vref_in` XOR `cfg_v_pol` is sampled 1 after a sample of 0. `cfg_v_dly` clock edges later (the same edge when 0), `line_cnt` loads `cfg_v_preset`. If `cfg_v_sets_h`=1, `pix_cnt` loads `cfg_h_preset` at the same edge.
- R5: In slave mode with `cfg_v_sets_h`=0, a horizontal edge (`href_in` XOR `cfg_h_pol` going 0 to 1) loads `pix_cnt` with `cfg_h_preset` after `cfg_h_dly` clock edges. `line_cnt` is untouched.
- R6: Reference input levels that are not qualified edges have no effect, and in master mode the inputs are ignored. In both cases the counters keep free-running.
- R7: When `cfg_v_sets_fld`=1, a vertical re-phase also sets `field_odd` to 1 and `field_seq` to 0.
- R8: Vertical output code 0 (`cfg_v_out_mode`=0) is raw-high on lines 0 to 2. With `cfg_vs_short`=1 it is raw-high on lines 0 and 1, and on line 2 only while `pix_cnt` < `cfg_line_len`/2.
- R9: Vertical output code 1 is raw-low while `field_odd`=1 and raw-high otherwise.
- R10: Vertical output code 2 is raw-high during fields with `field_seq`=0. `field_seq` wraps after 4, 8 or 12 fields for `cfg_seq_sel` 0, 1 or 2 (3 acts as 12).
- R11: `href_out` is raw-high while `cfg_hp_start` <= `pix_cnt` < `cfg_hp_stop`. With `cfg_hp_vblank_mask`=1 it is also held raw-low on lines where `vid_active`=0.
- R12: Each output is its raw value XOR its polarity bit (`cfg_v_pol`, `cfg_h_pol`). `vref_oe` equals `cfg_master`, and `href_oe` is `cfg_master` OR `cfg_v_sets_h`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_master | input | 1 | 1 = free-running master, 0 = slave |
| cfg_line_len | input | 11 | Pixels per line |
| cfg_field_len | input | 10 | Lines per field |
| cfg_act_first | input | 10 | First active line |
| cfg_act_last | input | 10 | Last active line |
| cfg_v_pol | input | 1 | Vertical reference polarity (input and output) |
| cfg_v_dly | input | 8 | Vertical edge trigger delay in clocks |
| cfg_h_pol | input | 1 | Horizontal reference polarity (input and output) |
| cfg_h_dly | input | 8 | Horizontal edge trigger delay in clocks |
| cfg_v_sets_h | input | 1 | Vertical edge also sets the pixel phase |
| cfg_v_sets_fld | input | 1 | Vertical edge also sets the field phase |
| cfg_h_preset | input | 11 | Pixel value loaded on re-phase |
| cfg_v_preset | input | 10 | Line value loaded on re-phase |
| cfg_v_out_mode | input | 2 | 0 vsync, 1 parity, 2 field sequence |
| cfg_vs_short | input | 1 | Vertical sync 2.5 lines instead of 3 |
| cfg_seq_sel | input | 2 | Sequence length 4, 8, 12 |
| cfg_hp_start | input | 11 | Horizontal pulse first pixel |
| cfg_hp_stop | input | 11 | Horizontal pulse end pixel (exclusive) |
| cfg_hp_vblank_mask | input | 1 | Suppress horizontal pulse on inactive lines |
| vref_in | input | 1 | Vertical reference input |
| href_in | input | 1 | Horizontal reference input |
| vref_out | output | 1 | Vertical reference output |
| vref_oe | output | 1 | Vertical reference drive enable |
| href_out | output | 1 | Horizontal reference output |
| href_oe | output | 1 | Horizontal reference drive enable |
| pix_cnt | output | 11 | Pixel position |
| line_cnt | output | 10 | Line position |
| field_odd | output | 1 | 1 in odd fields |
| field_seq | output | 4 | Field index within the sequence |
| vid_active | output | 1 | Line lies in the active region |

## Verification
The bench targets the exact clock at which a delayed re-phase lands. A delay counter that is off by one would move the counters a cycle early or late, and the checks just before and just after the load would catch it. It checks that only the qualified direction of an edge acts. A detector that ignored polarity would re-phase on the falling slope or reload on every level. It follows the field wrap after a re-phase, where a design that reset to zero instead of the preset, or lost the field phase, shows the wrong parity and sequence. Per-cycle sweeps over every vertical output code compare the 2.5-line half-line boundary, the parity sense and the 4/8/12 sequence wrap against a counting model.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    typedef enum logic [1:0] {
        VOUT_VSYNC  = 2'd0,
        VOUT_PARITY = 2'd1,
        VOUT_FSEQ   = 2'd2,
        VOUT_RSVD   = 2'd3
    } vout_mode_e;

    typedef enum logic [1:0] {
        SEQ_4  = 2'd0,
        SEQ_8  = 2'd1,
        SEQ_12 = 2'd2,
        SEQ_XX = 2'd3
    } seq_sel_e;
endpackage

// File: rtl/vtg_edge_delay.sv
module vtg_edge_delay #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pol,
    input  logic [DLY_W-1:0] dly,
    input  logic             sig,
    output logic             fire
);
    typedef struct packed {
        logic             prev;
        logic             armed;
        logic [DLY_W-1:0] cnt;
    } ed_t;

    ed_t st_q, st_d;
    logic norm, edge_c;

    always_comb begin
        st_d   = st_q;
        fire   = 1'b0;
        norm   = sig ^ pol;
        edge_c = en & norm & ~st_q.prev;
        st_d.prev = norm;
        if (st_q.armed) begin
            if (st_q.cnt == {{(DLY_W-1){1'b0}}, 1'b1}) begin
                fire       = en;
                st_d.armed = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
        if (edge_c) begin
            if (dly == '0) begin
                fire       = 1'b1;
                st_d.armed = 1'b0;
            end else begin
                st_d.armed = 1'b1;
                st_d.cnt   = dly;
            end
        end
        if (!en) st_d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/vtg_raster.sv
module vtg_raster #(
    parameter int PIX_W  = 11,
    parameter int LINE_W = 10,
    parameter int SEQ_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  line_len,
    input  logic [LINE_W-1:0] field_len,
    input  logic [SEQ_W-1:0]  seq_n,
    input  logic [PIX_W-1:0]  h_preset,
    input  logic [LINE_W-1:0] v_preset,
    input  logic              load_h,
    input  logic              load_v,
    input  logic              load_fld,
    output logic [PIX_W-1:0]  pix,
    output logic [LINE_W-1:0] line,
    output logic              odd,
    output logic [SEQ_W-1:0]  seq
);
    typedef struct packed {
        logic [PIX_W-1:0]  pix;
        logic [LINE_W-1:0] line;
        logic              odd;
        logic [SEQ_W-1:0]  seq;
    } rs_t;

    rs_t  st_q, st_d;
    logic pix_end, line_end;

    always_comb begin
        st_d     = st_q;
        pix_end  = (st_q.pix == line_len - 1'b1);
        line_end = (st_q.line == field_len - 1'b1);
        if (pix_end) begin
            st_d.pix = '0;
            if (line_end) begin
                st_d.line = '0;
                st_d.odd  = ~st_q.odd;
                st_d.seq  = (st_q.seq == seq_n - 1'b1) ? '0 : st_q.seq + 1'b1;
            end else begin
                st_d.line = st_q.line + 1'b1;
            end
        end else begin
            st_d.pix = st_q.pix + 1'b1;
        end
        if (load_h) st_d.pix = h_preset;
        if (load_v) begin
            st_d.line = v_preset;
            if (load_fld) begin
                st_d.odd = 1'b1;
                st_d.seq = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.odd  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix  = st_q.pix;
    assign line = st_q.line;
    assign odd  = st_q.odd;
    assign seq  = st_q.seq;

    AST_PIX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_end && !load_h) |=> (st_q.pix == '0));  // R1
    AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_end && !load_h) |=> (st_q.pix == $past(st_q.pix) + 1'b1));  // R1
    AST_FIELD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_end && line_end && !load_h && !load_v) |=> (st_q.line == '0 && st_q.odd != $past(st_q.odd)));  // R2
    AST_VLOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_v |=> (st_q.line == $past(v_preset)));  // R4
    AST_SEQ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.seq < seq_n));  // R10
endmodule

// File: rtl/vtg_sync_out.sv
module vtg_sync_out
    import vtg_pkg::*;
#(
    parameter int PIX_W  = 11,
    parameter int LINE_W = 10,
    parameter int SEQ_W  = 4
) (
    input  vout_mode_e        mode,
    input  logic              vs_short,
    input  logic              v_pol,
    input  logic              h_pol,
    input  logic              hp_mask,
    input  logic [PIX_W-1:0]  line_len,
    input  logic [PIX_W-1:0]  hp_start,
    input  logic [PIX_W-1:0]  hp_stop,
    input  logic [LINE_W-1:0] act_first,
    input  logic [LINE_W-1:0] act_last,
    input  logic [PIX_W-1:0]  pix,
    input  logic [LINE_W-1:0] line,
    input  logic              odd,
    input  logic [SEQ_W-1:0]  seq,
    output logic              v_out,
    output logic              h_out,
    output logic              active
);
    localparam logic [LINE_W-1:0] VS_LINES = LINE_W'(3);

    logic vs_raw, v_raw, h_raw;

    always_comb begin
        active = (line >= act_first) && (line <= act_last);
        if (vs_short)
            vs_raw = (line < VS_LINES - 1'b1) ||
                     ((line == VS_LINES - 1'b1) && (pix < (line_len >> 1)));
        else
            vs_raw = (line < VS_LINES);
        case (mode)
            VOUT_PARITY: v_raw = ~odd;
            VOUT_FSEQ:   v_raw = (seq == '0);
            default:     v_raw = vs_raw;
        endcase
        h_raw  = (pix >= hp_start) && (pix < hp_stop) && !(hp_mask && !active);
        v_out  = v_raw ^ v_pol;
        h_out  = h_raw ^ h_pol;
    end
endmodule

// File: rtl/vtg_timing_gen.sv
module vtg_timing_gen
    import vtg_pkg::*;
#(
    parameter int PIX_W  = 11,
    parameter int LINE_W = 10,
    parameter int DLY_W  = 8,
    parameter int SEQ_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic [PIX_W-1:0]  cfg_line_len,
    input  logic [LINE_W-1:0] cfg_field_len,
    input  logic [LINE_W-1:0] cfg_act_first,
    input  logic [LINE_W-1:0] cfg_act_last,
    input  logic              cfg_v_pol,
    input  logic [DLY_W-1:0]  cfg_v_dly,
    input  logic              cfg_h_pol,
    input  logic [DLY_W-1:0]  cfg_h_dly,
    input  logic              cfg_v_sets_h,
    input  logic              cfg_v_sets_fld,
    input  logic [PIX_W-1:0]  cfg_h_preset,
    input  logic [LINE_W-1:0] cfg_v_preset,
    input  logic [1:0]        cfg_v_out_mode,
    input  logic              cfg_vs_short,
    input  logic [1:0]        cfg_seq_sel,
    input  logic [PIX_W-1:0]  cfg_hp_start,
    input  logic [PIX_W-1:0]  cfg_hp_stop,
    input  logic              cfg_hp_vblank_mask,
    input  logic              vref_in,
    input  logic              href_in,
    output logic              vref_out,
    output logic              vref_oe,
    output logic              href_out,
    output logic              href_oe,
    output logic [PIX_W-1:0]  pix_cnt,
    output logic [LINE_W-1:0] line_cnt,
    output logic              field_odd,
    output logic [SEQ_W-1:0]  field_seq,
    output logic              vid_active
);
    logic             v_fire, h_fire, load_h;
    logic [SEQ_W-1:0] seq_n;

    always_comb begin
        case (seq_sel_e'(cfg_seq_sel))
            SEQ_4:   seq_n = SEQ_W'(4);
            SEQ_8:   seq_n = SEQ_W'(8);
            default: seq_n = SEQ_W'(12);
        endcase
        load_h = cfg_v_sets_h ? v_fire : h_fire;
    end

    vtg_edge_delay #(.DLY_W(DLY_W)) u_vrx (
        .clk(clk), .rst_n(rst_n), .en(!cfg_master), .pol(cfg_v_pol),
        .dly(cfg_v_dly), .sig(vref_in), .fire(v_fire)
    );

    vtg_edge_delay #(.DLY_W(DLY_W)) u_hrx (
        .clk(clk), .rst_n(rst_n), .en(!cfg_master && !cfg_v_sets_h), .pol(cfg_h_pol),
        .dly(cfg_h_dly), .sig(href_in), .fire(h_fire)
    );

    vtg_raster #(.PIX_W(PIX_W), .LINE_W(LINE_W), .SEQ_W(SEQ_W)) u_raster (
        .clk(clk), .rst_n(rst_n), .line_len(cfg_line_len), .field_len(cfg_field_len),
        .seq_n(seq_n), .h_preset(cfg_h_preset), .v_preset(cfg_v_preset),
        .load_h(load_h), .load_v(v_fire), .load_fld(cfg_v_sets_fld),
        .pix(pix_cnt), .line(line_cnt), .odd(field_odd), .seq(field_seq)
    );

    vtg_sync_out #(.PIX_W(PIX_W), .LINE_W(LINE_W), .SEQ_W(SEQ_W)) u_out (
        .mode(vout_mode_e'(cfg_v_out_mode)), .vs_short(cfg_vs_short),
        .v_pol(cfg_v_pol), .h_pol(cfg_h_pol), .hp_mask(cfg_hp_vblank_mask),
        .line_len(cfg_line_len), .hp_start(cfg_hp_start), .hp_stop(cfg_hp_stop),
        .act_first(cfg_act_first), .act_last(cfg_act_last),
        .pix(pix_cnt), .line(line_cnt), .odd(field_odd), .seq(field_seq),
        .v_out(vref_out), .h_out(href_out), .active(vid_active)
    );

    assign vref_oe = cfg_master;
    assign href_oe = cfg_master | cfg_v_sets_h;

    AST_MASTER_IGNORES_REF: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_master |-> !(v_fire || h_fire));  // R6
endmodule

// File: tb/vtg_timing_gen_test.sv
module vtg_timing_gen_test;
    localparam int L = 20;
    localparam int F = 7;
    localparam int AF = 2;
    localparam int AL = 4;
    localparam int HS = 5;
    localparam int HE = 12;

    // [7:6] vout mode, [5] short vsync, [4:3] seq select, [2] v pol, [1] h pol, [0] blank mask
    localparam logic [7:0] CFG_TAB [6] = '{
        {2'd0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},
        {2'd0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1},
        {2'd1, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0},
        {2'd2, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0},
        {2'd2, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1},
        {2'd2, 1'b0, 2'd2, 1'b0, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_master = 1'b1;
    logic [10:0] cfg_line_len = 11'(L);
    logic [9:0]  cfg_field_len = 10'(F);
    logic [9:0]  cfg_act_first = 10'(AF);
    logic [9:0]  cfg_act_last = 10'(AL);
    logic cfg_v_pol = 1'b0;
    logic [7:0] cfg_v_dly = 8'd0;
    logic cfg_h_pol = 1'b0;
    logic [7:0] cfg_h_dly = 8'd0;
    logic cfg_v_sets_h = 1'b0;
    logic cfg_v_sets_fld = 1'b0;
    logic [10:0] cfg_h_preset = '0;
    logic [9:0]  cfg_v_preset = '0;
    logic [1:0]  cfg_v_out_mode = '0;
    logic cfg_vs_short = 1'b0;
    logic [1:0] cfg_seq_sel = '0;
    logic [10:0] cfg_hp_start = 11'(HS);
    logic [10:0] cfg_hp_stop = 11'(HE);
    logic cfg_hp_vblank_mask = 1'b0;
    logic vref_in = 1'b0;
    logic href_in = 1'b0;
    logic vref_out, vref_oe, href_out, href_oe, field_odd, vid_active;
    logic [10:0] pix_cnt;
    logic [9:0]  line_cnt;
    logic [3:0]  field_seq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    vtg_timing_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_line_len(cfg_line_len),
        .cfg_field_len(cfg_field_len), .cfg_act_first(cfg_act_first), .cfg_act_last(cfg_act_last),
        .cfg_v_pol(cfg_v_pol), .cfg_v_dly(cfg_v_dly), .cfg_h_pol(cfg_h_pol), .cfg_h_dly(cfg_h_dly),
        .cfg_v_sets_h(cfg_v_sets_h), .cfg_v_sets_fld(cfg_v_sets_fld), .cfg_h_preset(cfg_h_preset),
        .cfg_v_preset(cfg_v_preset), .cfg_v_out_mode(cfg_v_out_mode), .cfg_vs_short(cfg_vs_short),
        .cfg_seq_sel(cfg_seq_sel), .cfg_hp_start(cfg_hp_start), .cfg_hp_stop(cfg_hp_stop),
        .cfg_hp_vblank_mask(cfg_hp_vblank_mask), .vref_in(vref_in), .href_in(href_in),
        .vref_out(vref_out), .vref_oe(vref_oe), .href_out(href_out), .href_oe(href_oe),
        .pix_cnt(pix_cnt), .line_cnt(line_cnt), .field_odd(field_odd), .field_seq(field_seq),
        .vid_active(vid_active)
    );

    always #4 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic enter_reset();
        rst_n = 1'b0;
        tick(1);
    endtask

    task automatic leave_reset();
        tick(1);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        // master sweeps driven from the table
        foreach (CFG_TAB[i]) begin
            enter_reset();
            cfg_master = 1'b1;
            cfg_v_out_mode = CFG_TAB[i][7:6];
            cfg_vs_short = CFG_TAB[i][5];
            cfg_seq_sel = CFG_TAB[i][4:3];
            cfg_v_pol = CFG_TAB[i][2];
            cfg_h_pol = CFG_TAB[i][1];
            cfg_hp_vblank_mask = CFG_TAB[i][0];
            leave_reset();
            if (i == 0) begin
                chk("R1", "reset pix", int'(pix_cnt), 0);
                chk("R1", "reset line", int'(line_cnt), 0);
                chk("R1", "reset odd", int'(field_odd), 1);
                chk("R1", "reset seq", int'(field_seq), 0);
                chk("R12", "master vref_oe", int'(vref_oe), 1);
                chk("R12", "master href_oe", int'(href_oe), 1);
            end
            for (int n = 0; n <= 13 * L * F; n++) begin
                int p, ln, fld, s, sn;
                bit act, vraw, hraw;
                p   = n % L;
                ln  = (n / L) % F;
                fld = n / (L * F);
                sn  = (cfg_seq_sel == 2'd0) ? 4 : (cfg_seq_sel == 2'd1) ? 8 : 12;
                s   = fld % sn;
                act = (ln >= AF) && (ln <= AL);
                case (cfg_v_out_mode)
                    2'd1: vraw = (fld % 2) == 1;
                    2'd2: vraw = (s == 0);
                    default: vraw = cfg_vs_short ? ((ln < 2) || (ln == 2 && p < L / 2)) : (ln < 3);
                endcase
                hraw = (p >= HS) && (p < HE) && !(cfg_hp_vblank_mask && !act);
                chk("R1", "pix", int'(pix_cnt), p);
                chk("R2", "line", int'(line_cnt), ln);
                chk("R2", "odd", int'(field_odd), int'((fld % 2) == 0));
                chk("R10", "seq", int'(field_seq), s);
                chk("R3", "active", int'(vid_active), int'(act));
                if (cfg_v_out_mode == 2'd1)
                    chk("R9", "vref parity", int'(vref_out), int'(vraw ^ cfg_v_pol));
                else if (cfg_v_out_mode == 2'd2)
                    chk("R10", "vref fseq", int'(vref_out), int'(vraw ^ cfg_v_pol));
                else
                    chk("R8", "vref vsync", int'(vref_out), int'(vraw ^ cfg_v_pol));
                chk("R11", "href pulse", int'(href_out), int'(hraw ^ cfg_h_pol));
                tick(1);
            end
        end

        // master ignores reference inputs
        enter_reset();
        cfg_v_pol = 1'b0; cfg_h_pol = 1'b0; cfg_v_dly = 8'd0; cfg_h_dly = 8'd0;
        cfg_h_preset = 11'd7; cfg_v_preset = 10'd5;
        leave_reset();
        tick(10);
        vref_in = 1'b1; href_in = 1'b1;
        tick(5);
        href_in = 1'b0;
        tick(5);
        href_in = 1'b1;
        tick(20);
        chk("R6", "master ignores inputs pix", int'(pix_cnt), 0);
        chk("R6", "master ignores inputs line", int'(line_cnt), 2);
        vref_in = 1'b0; href_in = 1'b0;

        // slave vertical re-phase with delay, pixel and field phase
        enter_reset();
        cfg_master = 1'b0; cfg_v_pol = 1'b0; cfg_v_dly = 8'd3;
        cfg_v_sets_h = 1'b1; cfg_v_sets_fld = 1'b1; cfg_seq_sel = 2'd0;
        leave_reset();
        chk("R12", "slave vref_oe", int'(vref_oe), 0);
        chk("R12", "href_oe when vertical sets pixel", int'(href_oe), 1);
        tick(150);
        chk("R2", "second field odd", int'(field_odd), 0);
        chk("R2", "second field seq", int'(field_seq), 1);
        chk("R2", "free line", int'(line_cnt), 0);
        vref_in = 1'b1;
        tick(3);
        chk("R4", "before delayed load pix", int'(pix_cnt), 13);
        chk("R4", "before delayed load line", int'(line_cnt), 0);
        tick(1);
        chk("R4", "delayed load pix", int'(pix_cnt), 7);
        chk("R4", "delayed load line", int'(line_cnt), 5);
        chk("R7", "field phase odd", int'(field_odd), 1);
        chk("R7", "field phase seq", int'(field_seq), 0);
        vref_in = 1'b0;
        tick(20);
        chk("R6", "falling slope no effect pix", int'(pix_cnt), 7);
        chk("R6", "falling slope no effect line", int'(line_cnt), 6);
        tick(13);
        chk("R6", "free run wrap pix", int'(pix_cnt), 0);
        chk("R6", "free run wrap line", int'(line_cnt), 0);
        chk("R2", "wrap after re-phase odd", int'(field_odd), 0);
        chk("R2", "wrap after re-phase seq", int'(field_seq), 1);

        // slave horizontal re-phase, inverted polarity
        enter_reset();
        cfg_master = 1'b0; cfg_v_sets_h = 1'b0; cfg_v_sets_fld = 1'b0;
        cfg_h_pol = 1'b1; cfg_h_dly = 8'd2; cfg_h_preset = 11'd3;
        href_in = 1'b1; vref_in = 1'b0;
        leave_reset();
        chk("R12", "slave href_oe", int'(href_oe), 0);
        tick(25);
        chk("R5", "idle high level no effect", int'(pix_cnt), 5);
        href_in = 1'b0;
        tick(2);
        chk("R5", "before delayed h load", int'(pix_cnt), 7);
        tick(1);
        chk("R5", "h load pix", int'(pix_cnt), 3);
        chk("R5", "h load keeps line", int'(line_cnt), 1);
        tick(4);
        chk("R6", "held level no reload", int'(pix_cnt), 7);

        finish_run();
    end
endmodule